// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an eight-pin general-purpose I/O port controlled through a small register interface. Software sets a direction per pin, writes an output latch that reaches only the pins set as outputs, and reads back the real level of every pin. The bus protocol and the pad cells sit outside the block. The block drives an output value vector and an output-enable vector, and it takes the pad level vector back in.

Each pin level passes through a two-flop synchronizer. When the synchronized level of an input pin changes and that pin's interrupt is enabled, a sticky interrupt flag is set. The flag clears when the direction register is written or when the state register is read. In modem mode, pins 7 to 4 take their interrupt permission from a single modem-interrupt enable bit instead of their own per-pin bits.

Register map: address 0 is direction, address 1 is state, address 2 is per-pin interrupt enable, and address 3 is mode control (bit 0 turns on modem mode, bit 1 is the modem-interrupt enable, and the other bits read 0).

Top module: `gpio_port`

## Requirements
- R1: After reset, pin_oe and pin_out are 0x00, irq is 0, and reads of addresses 0, 2 and 3 return 0x00.
- R2: Writing address 0 sets pin_oe to the written value, where bit n = 1 makes pin n an output. Reading address 0 returns that value.
- R3: A write to address 1 updates only the output-latch bits whose pins are outputs. Latch bits of input pins keep their earlier value, and this remains true after those pins are later switched to outputs.
- R4: Reading address 1 returns the level of all eight pins through a two-flop synchronizer. A change on pin_in appears in rdata after the second rising clock edge, and not after the first.
- R5: A level change on an input pin whose interrupt is enabled (address 2 bit = 1) raises irq on the third rising edge after the change. irq then stays high until it is cleared.
- R6: A level change does not raise irq on a pin whose enable bit is 0, and it does not raise irq on a pin configured as an output.
- R7: Any write to address 0 clears a pending interrupt, so irq is low after that write.
- R8: A read of address 1 (rd_en high) clears a pending interrupt.
- R9: In modem mode (address 3 bit 0 = 1), changes on input pins 7 to 4 raise irq only when address 3 bit 1 = 1, and address 2 bits 7 to 4 have no effect. Pins 3 to 0 keep using their own enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pin_in | input | 8 | Pad levels |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Change interrupt, active high |

## Verification
Single-bit toggles on one pin at a time separate an enabled pin from a disabled one. They also separate an input pin from an output pin that changes only through its own latch. State writes made under a mixed direction pattern show whether the latch is masked by direction or written whole. Toggles on upper pins with the per-pin enables and the modem enable set against each other show which enable source is active in each mode. The input path is sampled one edge and two edges after a change to confirm the synchronizer depth.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPIN = 8,
  parameter int NMODEM = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int NLOW = NPIN - NMODEM;
  localparam logic [1:0] A_DIR = 2'd0, A_STATE = 2'd1, A_IEN = 2'd2, A_MODE = 2'd3;

  logic [NPIN-1:0] dir_q, latch_q, ien_q, sync1_q, sync2_q, prev_q, ien_eff;
  logic            modem_q, mien_q, pend_q;

  wire wr_dir   = wr_en && addr == A_DIR;
  wire wr_state = wr_en && addr == A_STATE;
  wire clr      = wr_dir || (rd_en && addr == A_STATE);

  assign ien_eff = modem_q ? {{NMODEM{mien_q}}, ien_q[NLOW-1:0]} : ien_q;
  wire   hit     = |((sync2_q ^ prev_q) & ~dir_q & ien_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0; latch_q <= '0; ien_q <= '0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
      modem_q <= 1'b0; mien_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr_dir) dir_q <= wdata;
      if (wr_state) latch_q <= (latch_q & ~dir_q) | (wdata & dir_q);
      if (wr_en && addr == A_IEN) ien_q <= wdata;
      if (wr_en && addr == A_MODE) begin
        modem_q <= wdata[0];
        mien_q  <= wdata[1];
      end
      // a fresh event in the clearing cycle stays pending
      if (hit) pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_STATE: rdata = sync2_q;
      A_IEN:   rdata = ien_q;
      default: rdata = {{(NPIN-2){1'b0}}, mien_q, modem_q};
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = latch_q;
  assign irq     = pend_q;

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIR) |=> $stable(pin_oe));

  // R3
  latch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  // R7
  dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !hit) |=> !irq);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STATE && !hit) |=> !irq);

  // R6
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|((sync2_q ^ prev_q) & ~dir_q)));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, ext = 0, rdata, pin_out, pin_oe, pin_in;
  logic irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle_clear();
    logic [7:0] d;
    edges(4); rd(2'd1, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pin_oe, 8'h00); chk("R1 out", pin_out, 8'h00); chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0, d); chk("R1 dir", d, 8'h00);
    rd(2'd2, d); chk("R1 ien", d, 8'h00);
    rd(2'd3, d); chk("R1 mode", d, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr(2'd0, 8'hA5); chk("R2 oe", pin_oe, 8'hA5);
    rd(2'd0, d); chk("R2 readback", d, 8'hA5);
  endtask

  task automatic t_latch();
    wr(2'd0, 8'h0F); wr(2'd1, 8'hFF); chk("R3 masked", pin_out, 8'h0F);
    wr(2'd0, 8'hFF); chk("R3 kept", pin_out, 8'h0F);
    wr(2'd1, 8'h3C); chk("R3 full", pin_out, 8'h3C);
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(2'd0, 8'h0F); wr(2'd1, 8'h05); ext = 8'h90; edges(3);
    rd(2'd1, d); chk("R4 levels", d, 8'h95);
    @(negedge clk); addr = 2'd1; ext = 8'h60;
    @(negedge clk); chk("R4 one edge", rdata, 8'h95);
    @(negedge clk); chk("R4 two edges", rdata, 8'h65);
    wr(2'd0, 8'h00); ext = 8'h00; settle_clear();
  endtask

  task automatic t_irq();
    wr(2'd2, 8'h01); settle_clear();
    ext[0] = 1;
    edges(2); chk("R5 not yet", {7'd0, irq}, 8'h00);
    edges(1); chk("R5 raised", {7'd0, irq}, 8'h01);
    edges(4); chk("R5 held", {7'd0, irq}, 8'h01);
    settle_clear(); chk("R8 read clears", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_masked();
    ext[1] = 1; edges(5); chk("R6 disabled pin", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h04); wr(2'd2, 8'h04); settle_clear();
    wr(2'd1, 8'h04); edges(5); chk("R6 output pin", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00); edges(5); chk("R6 output pin low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_dirclr();
    wr(2'd2, 8'h01); wr(2'd0, 8'h00); settle_clear();
    ext[0] = 0; edges(4); chk("R7 pending", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h00); chk("R7 dir write clears", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_modem();
    logic [7:0] d;
    wr(2'd2, 8'hF0); wr(2'd3, 8'h01); settle_clear();
    ext[4] = 1; edges(5); chk("R9 per-pin ignored", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h03); wr(2'd2, 8'h00); settle_clear();
    ext[5] = 1; edges(4); chk("R9 modem enable", {7'd0, irq}, 8'h01);
    settle_clear();
    ext[0] = 1; edges(5); chk("R9 low pin own enable", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h01); settle_clear();
    ext[0] = 0; edges(4); chk("R9 low pin enabled", {7'd0, irq}, 8'h01);
    rd(2'd3, d); chk("R9 mode readback", d, 8'h03);
  endtask

  initial begin
    edges(3); rst_n = 1; @(negedge clk);
    t_reset(); t_dir(); t_latch(); t_read(); t_irq(); t_masked(); t_dirclr(); t_modem();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule